// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block loads a configuration image into an FPGA that accepts its image as an SPI slave. It controls the target's active-low reset line and its active-low select line, and it reads the target's configuration-done signal. The image reaches the block as a stream of bytes on a valid/ready input, and the block sends it out as an SPI mode 0 master, most significant bit first. The serial clock is derived from the system clock by a parameterised half-period count.

The host pulses `start_i` to begin a load. The block then runs a fixed sequence. It pulses the target's reset with select held low and checks that the done signal is low. It holds select through a housekeeping wait, streams the image, and checks that done has gone high. It then sends seven zero bytes so that the loaded design starts. Busy, done and error outputs report the outcome, and a two-bit code says why a load failed. The target's reset line is held high from power-up whenever no load is in progress. This keeps the target from starting on its own and driving the shared serial clock.

Top module: `fpga_cfg_loader`

## Requirements
- R1: From reset and while idle, `tgt_rst_n_o` and `tgt_ss_n_o` are 1, `tgt_sck_o` is 0, and `busy_o`, `done_o`, `err_o` and `img_ready_o` are 0.
- R2: A start with `partial_i`=1 is refused. One cycle later `err_o` is 1 with `err_code_o`=1, and no target pin ever changes.
- R3: If `SCK_HALF` gives a serial clock above 25 MHz or below 1 MHz, every start is refused the same way as in R2, with code 1 and no pin activity.
- R4: An accepted start drives `tgt_ss_n_o` and `tgt_rst_n_o` low in the same cycle. Reset stays low for exactly `RST_CYCLES` cycles and select stays low when reset is released.
- R5: The synchronised done input is sampled 2 cycles after reset is released. If it is high, the load ends with code 2, select is released, and no serial clock is sent.
- R6: After a passing reset check, select stays low for `HOUSE_CYCLES` more cycles. Select is therefore low for `RST_CYCLES`+3+`HOUSE_CYCLES` cycles in a row, then high for exactly one cycle before streaming.
- R7: Serial output is mode 0 and MSB first. The clock idles low and each high and low phase lasts `SCK_HALF` cycles. `tgt_mosi_o` changes only while the clock is low, and the target samples it on the rising edge.
- R8: `img_ready_o` is 1 only while streaming, with no byte in flight and the last byte not yet taken. While `img_valid_i` is 0 no serial clock edges occur.
- R9: The done input is sampled 3 cycles after the byte marked `img_last_i` has been fully sent. If it is low, the load ends with code 3 and no padding is sent.
- R10: If done is high after the image, 56 zero bits are clocked out with select low. Then `done_o` is 1 with `err_code_o`=0.
- R11: `busy_o` is 1 from the cycle after an accepted or refused start up to and including the single cycle in which `done_o` or `err_o` is 1. It is 0 in the following cycle. `err_code_o` keeps its value until the next start.
- R12: A start pulse while `busy_o` is 1 has no effect on the load in progress, and this holds even if `partial_i` is 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse from the host |
| partial_i | input | 1 | Host asks for partial reconfiguration (refused) |
| busy_o | output | 1 | A load or refusal is in progress |
| done_o | output | 1 | One-cycle success indication |
| err_o | output | 1 | One-cycle failure indication |
| err_code_o | output | 2 | 0 none, 1 invalid request, 2 reset check failed, 3 done low after image |
| img_data_i | input | 8 | Image byte |
| img_valid_i | input | 1 | Image byte valid |
| img_last_i | input | 1 | Marks the final image byte |
| img_ready_o | output | 1 | Block accepts the offered byte |
| tgt_rst_n_o | output | 1 | Target reset, active low |
| tgt_ss_n_o | output | 1 | Target select, active low |
| tgt_sck_o | output | 1 | Serial clock |
| tgt_mosi_o | output | 1 | Serial data to the target |
| tgt_done_i | input | 1 | Target configuration-done, asynchronous |

## Verification
The bench sweeps image lengths of one to four bytes, with gaps between bytes and without them, and compares every captured serial bit against the byte pattern it computed. An off-by-one in the half-period or bit counters would add or drop clocks, so the bench would see a wrong bit count or a wrong high-phase width. If the done-check polarity were swapped, a good load would be reported as failed, or a stuck-done target would not be rejected. If padding were missing, the 56 trailing zeros would not appear. A refused request that still moved a pin, a select window that was one cycle short of housekeeping, or a start during a load that restarted the sequence would each change the measured select-low run or the final code.

// File: rtl/cfgld_pkg.sv
// Shared types and constants for the configuration sequencer.
// Assumes: error code values are visible to host software and must stay fixed.
package cfgld_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST,
        ST_RCHK,
        ST_HOUSE,
        ST_GAP,
        ST_STREAM,
        ST_DCHK,
        ST_PAD,
        ST_FIN
    } ld_state_t;

    localparam logic [1:0] ERR_NONE   = 2'd0;
    localparam logic [1:0] ERR_INVAL  = 2'd1;
    localparam logic [1:0] ERR_RSTCHK = 2'd2;
    localparam logic [1:0] ERR_NODONE = 2'd3;

    localparam int PAD_BYTES = 7;  // 56 zero clocks, above the 49 needed
    localparam int CHK_WAIT  = 2;  // cycles to let the synchroniser settle

endpackage

// File: rtl/cfgld_sync.sv
// Multi-flop synchroniser for one asynchronous level input.
// Assumes: STAGES >= 2; input is a slow level, not a pulse.
module cfgld_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfgld_shift.sv
// SPI mode 0 byte shifter, MSB first. A load while idle starts a byte.
// The clock idles low and each phase lasts SCK_HALF system cycles.
// Assumes: load_i is only honoured while idle_o is high.
module cfgld_shift #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       idle_o
);
    localparam int HALF_W = $clog2(SCK_HALF + 1);
    localparam logic [HALF_W-1:0] HALF_END = HALF_W'(SCK_HALF - 1);

    logic              active_q;
    logic              sck_q;
    logic [7:0]        sr_q;
    logic [HALF_W-1:0] hcnt_q;
    logic [2:0]        bcnt_q;

    // phase timing, clock toggling and shifting on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sck_q    <= 1'b0;
            sr_q     <= '0;
            hcnt_q   <= '0;
            bcnt_q   <= '0;
        end else if (load_i && !active_q) begin
            active_q <= 1'b1;
            sck_q    <= 1'b0;
            sr_q     <= byte_i;
            hcnt_q   <= '0;
            bcnt_q   <= '0;
        end else if (active_q) begin
            if (hcnt_q == HALF_END) begin
                hcnt_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                end else begin
                    sck_q  <= 1'b0;
                    sr_q   <= {sr_q[6:0], 1'b0};
                    bcnt_q <= bcnt_q + 3'd1;
                    if (bcnt_q == 3'd7) active_q <= 1'b0;
                end
            end else begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end
    end

    assign sck_o  = sck_q;
    assign mosi_o = sr_q[7];
    assign idle_o = !active_q;

    // R7: data never moves while the clock is high
    a_r7_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> $stable(mosi_o));
    // R7: clock rests low between bytes
    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> !sck_o);
endmodule

// File: rtl/fpga_cfg_loader.sv
// Configuration sequencer for an FPGA loaded over slave SPI.
// Sequence: reset pulse with select held, done-low check, housekeeping wait,
// image stream, done-high check, zero padding, then status.
// Assumes: tgt_done_i is asynchronous; the image source holds a byte stable
// while valid is high; the SPI bus is not shared during a load.
module fpga_cfg_loader #(
    parameter int CLK_HZ       = 100_000_000,
    parameter int SCK_HALF     = 2,
    parameter int RST_CYCLES   = 100,
    parameter int HOUSE_CYCLES = 120_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       partial_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic [1:0] err_code_o,
    input  logic [7:0] img_data_i,
    input  logic       img_valid_i,
    input  logic       img_last_i,
    output logic       img_ready_o,
    output logic       tgt_rst_n_o,
    output logic       tgt_ss_n_o,
    output logic       tgt_sck_o,
    output logic       tgt_mosi_o,
    input  logic       tgt_done_i
);
    import cfgld_pkg::*;

    localparam int SCK_MAX_HZ = 25_000_000;
    localparam int SCK_MIN_HZ = 1_000_000;
    localparam int HALF_MIN   = (CLK_HZ + 2 * SCK_MAX_HZ - 1) / (2 * SCK_MAX_HZ);
    localparam int HALF_MAX   = CLK_HZ / (2 * SCK_MIN_HZ);
    localparam bit DIV_OK     = (SCK_HALF >= HALF_MIN) && (SCK_HALF <= HALF_MAX);
    localparam int TMR_TOP    = (RST_CYCLES > HOUSE_CYCLES) ? RST_CYCLES : HOUSE_CYCLES;
    localparam int TMR_W      = $clog2(TMR_TOP + 1);
    localparam int PAD_W      = $clog2(PAD_BYTES + 1);

    ld_state_t          state_q;
    logic [TMR_W-1:0]   tmr_q;
    logic [PAD_W-1:0]   pad_cnt_q;
    logic               last_seen_q;
    logic [1:0]         code_q;
    logic               done_s;
    logic               sh_idle;
    logic               accept;
    logic               pad_load;
    logic               sh_load;
    logic [7:0]         sh_byte;

    cfgld_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (tgt_done_i),
        .q_o   (done_s)
    );

    cfgld_shift #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sh_load),
        .byte_i (sh_byte),
        .sck_o  (tgt_sck_o),
        .mosi_o (tgt_mosi_o),
        .idle_o (sh_idle)
    );

    // byte intake and padding feed for the shifter
    always_comb begin
        img_ready_o = (state_q == ST_STREAM) && sh_idle && !last_seen_q;
        accept      = img_ready_o && img_valid_i;
        pad_load    = (state_q == ST_PAD) && sh_idle &&
                      (pad_cnt_q != PAD_W'(PAD_BYTES));
        sh_load     = accept || pad_load;
        sh_byte     = (state_q == ST_PAD) ? 8'h00 : img_data_i;
    end

    // sequence control, phase timer and result code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            tmr_q       <= '0;
            pad_cnt_q   <= '0;
            last_seen_q <= 1'b0;
            code_q      <= ERR_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    tmr_q       <= '0;
                    pad_cnt_q   <= '0;
                    last_seen_q <= 1'b0;
                    if (start_i) begin
                        if (partial_i || !DIV_OK) begin
                            code_q  <= ERR_INVAL;
                            state_q <= ST_FIN;
                        end else begin
                            code_q  <= ERR_NONE;
                            state_q <= ST_RST;
                        end
                    end
                end
                ST_RST: begin
                    if (tmr_q == TMR_W'(RST_CYCLES - 1)) begin
                        tmr_q   <= '0;
                        state_q <= ST_RCHK;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_RCHK: begin
                    if (tmr_q == TMR_W'(CHK_WAIT)) begin
                        tmr_q <= '0;
                        if (done_s) begin
                            code_q  <= ERR_RSTCHK;
                            state_q <= ST_FIN;
                        end else begin
                            state_q <= ST_HOUSE;
                        end
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_HOUSE: begin
                    if (tmr_q == TMR_W'(HOUSE_CYCLES - 1)) begin
                        tmr_q   <= '0;
                        state_q <= ST_GAP;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_GAP: begin
                    state_q <= ST_STREAM;
                end
                ST_STREAM: begin
                    if (accept && img_last_i) last_seen_q <= 1'b1;
                    if (last_seen_q && sh_idle) begin
                        tmr_q   <= '0;
                        state_q <= ST_DCHK;
                    end
                end
                ST_DCHK: begin
                    if (tmr_q == TMR_W'(CHK_WAIT)) begin
                        tmr_q <= '0;
                        if (!done_s) begin
                            code_q  <= ERR_NODONE;
                            state_q <= ST_FIN;
                        end else begin
                            state_q <= ST_PAD;
                        end
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_PAD: begin
                    if (pad_load) pad_cnt_q <= pad_cnt_q + 1'b1;
                    if (sh_idle && pad_cnt_q == PAD_W'(PAD_BYTES)) state_q <= ST_FIN;
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // pin and status decode from the sequence state
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_FIN) && (code_q == ERR_NONE);
        err_o       = (state_q == ST_FIN) && (code_q != ERR_NONE);
        err_code_o  = code_q;
        tgt_rst_n_o = (state_q != ST_RST);
        tgt_ss_n_o  = !((state_q == ST_RST)    || (state_q == ST_RCHK) ||
                        (state_q == ST_HOUSE)  || (state_q == ST_STREAM) ||
                        (state_q == ST_DCHK)   || (state_q == ST_PAD));
    end

    // R2, R3: a refused start reports code 1 next cycle with pins quiet
    a_r2_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (partial_i || !DIV_OK)) |=>
        (err_o && err_code_o == ERR_INVAL && tgt_ss_n_o && tgt_rst_n_o));
    // R4: target reset is only pulled while selected
    a_r4_sel_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_rst_n_o |-> !tgt_ss_n_o);
    // R8: no serial clock outside the select window
    a_r8_sck_selected: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sck_o |-> !tgt_ss_n_o);
    // R8: bytes are only taken during a load
    a_r8_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready_o |-> busy_o);
    // R10: success always carries the zero code
    a_r10_done_code: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (err_code_o == ERR_NONE && !err_o));
    // R12: a start during a load does not end or restart it
    a_r12_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !done_o && !err_o) |=> busy_o);
endmodule

// File: tb/fpga_cfg_loader_bench.sv
module fpga_cfg_loader_bench;
    localparam int RSTC  = 5;
    localparam int HOUSE = 20;
    localparam int HALF  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, partial = 1'b0;
    logic [7:0] data = 8'h00;
    logic valid = 1'b0, last = 1'b0;
    logic tdone = 1'b0;
    logic busy, done, err, ready, trst_n, tss_n, tsck, tmosi;
    logic [1:0] code;

    logic b_start = 1'b0;
    logic b_busy, b_done, b_err, b_ready, b_rst_n, b_ss_n, b_sck, b_mosi;
    logic [1:0] b_code;

    int total = 0, bad = 0, cyc = 0;

    always #5 clk = ~clk;

    fpga_cfg_loader #(.CLK_HZ(100_000_000), .SCK_HALF(HALF),
                      .RST_CYCLES(RSTC), .HOUSE_CYCLES(HOUSE)) u_fpga_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .partial_i(partial),
        .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(code),
        .img_data_i(data), .img_valid_i(valid), .img_last_i(last),
        .img_ready_o(ready), .tgt_rst_n_o(trst_n), .tgt_ss_n_o(tss_n),
        .tgt_sck_o(tsck), .tgt_mosi_o(tmosi), .tgt_done_i(tdone));

    // second copy with a 50 MHz serial clock, which must be refused
    fpga_cfg_loader #(.CLK_HZ(100_000_000), .SCK_HALF(1),
                      .RST_CYCLES(RSTC), .HOUSE_CYCLES(HOUSE)) u_fast (
        .clk(clk), .rst_n(rst_n), .start_i(b_start), .partial_i(1'b0),
        .busy_o(b_busy), .done_o(b_done), .err_o(b_err), .err_code_o(b_code),
        .img_data_i(8'h00), .img_valid_i(1'b0), .img_last_i(1'b0),
        .img_ready_o(b_ready), .tgt_rst_n_o(b_rst_n), .tgt_ss_n_o(b_ss_n),
        .tgt_sck_o(b_sck), .tgt_mosi_o(b_mosi), .tgt_done_i(1'b0));

    // target model: capture data on rising serial clock while selected
    logic bits_q [0:1023];
    int nbits = 0;
    always @(posedge tsck) begin
        if (!tss_n && nbits < 1024) begin
            bits_q[nbits] = tmosi;
            nbits++;
        end
    end

    // pin timing monitors, sampled away from the clock edge
    int hi_run = 0, hi_min = 1000, hi_max = 0;
    int ss_run = 0, ss_runs = 0, ss_first = 0, rst_low = 0;
    always @(negedge clk) begin
        if (tsck) hi_run++;
        else if (hi_run > 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
        if (!tss_n) ss_run++;
        else if (ss_run > 0) begin
            if (ss_runs == 0) ss_first = ss_run;
            ss_runs++;
            ss_run = 0;
        end
        if (!trst_n) rst_low++;
    end

    // watchdog: a hung run is a failure but still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL R11 watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        nbits = 0; hi_run = 0; hi_min = 1000; hi_max = 0;
        ss_run = 0; ss_runs = 0; ss_first = 0; rst_low = 0;
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed * 11 + 165) & 255);
    endfunction

    task automatic do_start(input logic p);
        @(negedge clk); start = 1'b1; partial = p;
        @(negedge clk); start = 1'b0; partial = 1'b0;
    endtask

    // wait for done or err; checks busy stays high until then (R11)
    task automatic wait_fin(output int lat, output bit busy_ok);
        busy_ok = 1'b1;
        lat = -1;
        for (int c = 0; c < 5000; c++) begin
            if (done || err) begin lat = c; break; end
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
        end
    endtask

    // stream n bytes; gap>0 holds valid low between bytes and checks the pause
    task automatic send_img(input int n, input int gap, input int seed, input bit raise);
        for (int i = 0; i < n; i++) begin
            while (!ready) @(negedge clk);
            if (gap > 0 && i > 0) begin
                int nb0;
                nb0 = nbits;
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    chk(!tsck, "R8", "sck high while no valid", tsck, 0);
                end
                chk(nbits == nb0, "R8", "clock edges during pause", nbits - nb0, 0);
            end
            data = pat(i, seed); valid = 1'b1; last = (i == n - 1);
            while (!ready) @(negedge clk);
            @(negedge clk);
            valid = 1'b0; last = 1'b0;
            if (i == n - 1 && raise) tdone = 1'b1;
        end
    endtask

    task automatic run_load(input int n, input int gap, input int seed,
                            input bit good, input bit poke);
        int lat, mism;
        bit bok;
        clear_mon();
        tdone = 1'b0;
        do_start(1'b0);
        if (poke) begin
            // R12: start with partial set during housekeeping must be ignored
            repeat (8) @(negedge clk);
            start = 1'b1; partial = 1'b1;
            @(negedge clk);
            start = 1'b0; partial = 1'b0;
        end
        send_img(n, gap, seed, good);
        wait_fin(lat, bok);
        chk(bok, "R11", "busy dropped before finish", 0, 1);
        if (good) begin
            chk(done && !err, "R10", "done pulse", done, 1);
            chk(code == 2'd0, "R10", "code on success", code, 0);
            chk(nbits == n * 8 + 56, "R10", "bit count with padding", nbits, n * 8 + 56);
        end else begin
            chk(err && !done, "R9", "err pulse", err, 1);
            chk(code == 2'd3, "R9", "code for done low", code, 3);
            chk(nbits == n * 8, "R9", "no padding after failure", nbits, n * 8);
        end
        if (poke) chk(code != 2'd1, "R12", "start during load took effect", code, good ? 0 : 3);
        mism = 0;
        for (int i = 0; i < n; i++)
            for (int k = 0; k < 8; k++)
                if (bits_q[i * 8 + k] !== pat(i, seed)[7 - k]) mism++;
        chk(mism == 0, "R7", "image bits MSB first", mism, 0);
        if (good) begin
            mism = 0;
            for (int k = n * 8; k < n * 8 + 56; k++) if (bits_q[k] !== 1'b0) mism++;
            chk(mism == 0, "R10", "padding bits zero", mism, 0);
        end
        chk(hi_min == HALF && hi_max == HALF, "R7", "sck high width", hi_max, HALF);
        chk(rst_low == RSTC, "R4", "reset low cycles", rst_low, RSTC);
        chk(ss_first == RSTC + 3 + HOUSE, "R6", "select low before stream",
            ss_first, RSTC + 3 + HOUSE);
        @(negedge clk);
        chk(!busy && !done && !err, "R11", "idle after status cycle", busy, 0);
        chk(ss_runs == 2, "R6", "single one-cycle select gap", ss_runs, 2);
        chk(code == (good ? 2'd0 : 2'd3), "R11", "code held", code, good ? 0 : 3);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int lat;
        bit bok;
        // R1: reset values, also while reset is asserted
        @(negedge clk);
        chk(trst_n == 1'b1, "R1", "target reset during reset", trst_n, 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(trst_n && tss_n && !tsck, "R1", "idle pins", {trst_n, tss_n, tsck}, 6);
        chk(!busy && !done && !err && !ready, "R1", "idle status", {busy, done, err, ready}, 0);

        // R2: partial request refused, pins untouched
        clear_mon();
        do_start(1'b1);
        wait_fin(lat, bok);
        chk(lat == 0 && err && code == 2'd1, "R2", "refusal code", code, 1);
        chk(busy, "R11", "busy during refusal status", busy, 1);
        @(negedge clk);
        chk(!busy, "R11", "busy after refusal", busy, 1'b0);
        chk(ss_runs == 0 && ss_run == 0 && rst_low == 0 && nbits == 0,
            "R2", "pin activity on refusal", ss_runs + rst_low + nbits, 0);

        // R3: over-speed divider refused
        @(negedge clk); b_start = 1'b1;
        @(negedge clk); b_start = 1'b0;
        chk(b_err && b_code == 2'd1, "R3", "divider refusal code", b_code, 1);
        chk(b_ss_n && b_rst_n && !b_sck, "R3", "pins on divider refusal",
            {b_ss_n, b_rst_n, b_sck}, 6);

        // R5: done stuck high after reset
        clear_mon();
        tdone = 1'b1;
        do_start(1'b0);
        wait_fin(lat, bok);
        chk(err && code == 2'd2, "R5", "reset check code", code, 2);
        chk(tss_n, "R5", "select released on failure", tss_n, 1);
        chk(rst_low == RSTC, "R4", "reset low cycles", rst_low, RSTC);
        @(negedge clk);
        chk(ss_first == RSTC + 3, "R5", "select low span", ss_first, RSTC + 3);
        chk(nbits == 0, "R5", "no clocks after reset failure", nbits, 0);
        tdone = 1'b0;
        repeat (3) @(negedge clk);

        // sweep of image lengths and pacing
        for (int n = 1; n <= 4; n++) begin
            run_load(n, 0, n, 1'b1, n == 2);
            run_load(n, 3, n + 7, 1'b1, 1'b0);
        end
        // R9: done never rises
        run_load(3, 2, 5, 1'b0, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule